// File: doc/BRIEF.md
# Paged Memory Bank Controller with Per-Bank Write Protect

This block sits on a plug-in board that carries one 32 KiB static RAM and one piggyback ROM of up to 32 KiB, and listens on the processor bus of its host. The host has a paged-bank select register. The block keeps its own copy of that register by latching the low nibble of the data bus on every register write. From this copy it decides whether its socket is the one selected and which 16 KiB half of which chip to enable. It then drives the RAM and ROM chip selects and the upper memory address line that splits each 32 KiB chip into two halves.

The board needs no jumpers. After reset it does not know which of four sockets it occupies. It records the socket number on the first read of the paged window at 0x8000 to 0xBFFF, which happens while the system scans the banks at start-up. Each of the two RAM halves has its own write-protect flag. Software sets or clears a flag by writing a command value to the bank-select register. A protected half stays readable. During writes only its chip select is withheld, and the RAM write-enable follows the host write strobe unchanged.

Top module: `pgmem_ctrl`

## Requirements
- R1: After reset the latched bank is 0, both protect flags are clear and the socket is unknown. A read of the window with the socket enable high enables the RAM lower half (ram_cs=1, rom_cs=0, mem_a14=0).
- R2: On a clock edge where reg_sel and cpu_wr are both high, cpu_data[3:0] becomes the selected bank. If reg_sel is high while cpu_wr is low, the selected bank does not change.
- R3: Bits 3:2 of the selected bank choose the half. 00 is RAM low and 01 is RAM high. 10 is ROM low and 11 is ROM high. mem_a14 equals bank bit 2, and ram_cs and rom_cs are never high together.
- R4: No chip select is asserted unless slot_en is high and cpu_addr lies in 0x8000 to 0xBFFF.
- R5: The first window read with slot_en high while the socket is unknown stores bank bits 1:0 as the socket number. That read is served in the same cycle. The socket number then stays unchanged until reset.
- R6: Once the socket is known, no chip select is asserted when bank bits 1:0 differ from it.
- R7: A latched value 0x2X sets the protect flag of bank X, and 0x3X clears it. The change takes effect from the next cycle, and X also becomes the selected bank.
- R8: A set or clear command changes no flag when X belongs to another socket (X[1:0] differs from the socket) or names a ROM half (X[3]=1).
- R9: Set and clear commands received while the socket is unknown change no flag.
- R10: During a write (cpu_wr=1) to a protected RAM half, ram_cs stays low. Reads of that half still assert ram_cs, and ram_we always equals cpu_wr.
- R11: Latched values with bits 7:6 non-zero, and values whose upper nibble is neither 2 nor 3, select bank data[3:0] and leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_data | input | 8 | Processor data bus (write data) |
| cpu_wr | input | 1 | Synchronous write strobe, high during a write cycle |
| reg_sel | input | 1 | Host decode of the bank-select register address |
| slot_en | input | 1 | Socket enable from the host decoder |
| ram_cs | output | 1 | RAM chip select, active high |
| rom_cs | output | 1 | ROM chip select, active high |
| mem_a14 | output | 1 | Upper address line to both memory chips |
| ram_we | output | 1 | RAM write enable, follows cpu_wr |

## Verification
Two functions can meet in the first window read after reset. That single cycle must drive a chip select from the unknown-socket path and also load the socket register, and the bench checks both the select in that cycle and the filtering on later reads. The other meeting point is a protect command followed at once by a write to the half it names. The flag update and the select gating then fall on adjacent edges, and the bench judges ram_cs in the very next cycle after the command, in both the blocked and the released direction.

// File: rtl/pgmem_pkg.sv
// Shared constants and types for the paged memory bank controller.
// Assumes 16 banks (4-bit number), four sockets, two halves per chip.
package pgmem_pkg;
    localparam int BANK_W   = 4;
    localparam int SOCK_W   = 2;
    localparam int HALVES   = 2;
    localparam int KIND_W   = BANK_W - SOCK_W;

    // Half selected by bank bits 3:2
    typedef enum logic [KIND_W-1:0] {
        HALF_RAM_LO = 2'b00,
        HALF_RAM_HI = 2'b01,
        HALF_ROM_LO = 2'b10,
        HALF_ROM_HI = 2'b11
    } half_e;

    // Command opcodes carried in the upper nibble of the register value
    localparam logic [3:0] OP_PROT_SET = 4'h2;
    localparam logic [3:0] OP_PROT_CLR = 4'h3;

    typedef struct packed {
        logic              vld;
        logic              set;
        logic [BANK_W-1:0] bank;
    } prot_cmd_t;

    // True when a bank number names a RAM half
    function automatic logic is_ram_bank(input logic [BANK_W-1:0] b);
        return (b[BANK_W-1] == 1'b0);
    endfunction
endpackage

// File: rtl/pgmem_bank_reg.sv
// Shadow of the host bank-select register.
// Captures the low nibble of the data bus when the register strobe and the
// write strobe coincide, and decodes set/clear protect commands from the
// same byte. Assumes one register write per qualifying clock edge.
module pgmem_bank_reg
    import pgmem_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_data,
    output logic [BANK_W-1:0] bank_q,
    output prot_cmd_t         cmd
);
    localparam int OP_LSB = BANK_W;
    localparam int OP_MSB = (OP_LSB + 3 < DATA_W) ? OP_LSB + 3 : DATA_W - 1;

    logic              wr_hit;
    logic [3:0]        op;

    assign wr_hit = reg_sel & cpu_wr;

    // Extract the opcode nibble, padding with zero for narrow buses
    always_comb begin
        op = '0;
        op[OP_MSB-OP_LSB:0] = cpu_data[OP_MSB:OP_LSB];
    end

    // Decode a protect command from the byte being written
    always_comb begin
        cmd.bank = cpu_data[BANK_W-1:0];
        cmd.set  = (op == OP_PROT_SET);
        cmd.vld  = wr_hit & ((op == OP_PROT_SET) | (op == OP_PROT_CLR));
    end

    // Latch the selected bank on each register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else if (wr_hit)
            bank_q <= cpu_data[BANK_W-1:0];
    end
endmodule

// File: rtl/pgmem_socket_id.sv
// Socket position learner.
// Stores bank bits 1:0 on the first read of the paged window with the socket
// enable high, and holds that value until the next reset.
module pgmem_socket_id
    import pgmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hit,
    input  logic [BANK_W-1:0] bank_q,
    output logic [SOCK_W-1:0] sock,
    output logic              sock_vld
);
    // Record the socket once, at the first qualifying read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sock     <= '0;
            sock_vld <= 1'b0;
        end else if (rd_hit && !sock_vld) begin
            sock     <= bank_q[SOCK_W-1:0];
            sock_vld <= 1'b1;
        end
    end
endmodule

// File: rtl/pgmem_wp_flags.sv
// Write-protect flags, one per RAM half.
// A command changes a flag only when the socket is known, the bank belongs to
// this socket and names that RAM half. Flags reset to cleared.
module pgmem_wp_flags
    import pgmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  prot_cmd_t         cmd,
    input  logic [SOCK_W-1:0] sock,
    input  logic              sock_vld,
    output logic [HALVES-1:0] wp
);
    logic own_ram;

    // Command qualifies for this board's RAM
    assign own_ram = cmd.vld & sock_vld & is_ram_bank(cmd.bank)
                   & (cmd.bank[SOCK_W-1:0] == sock);

    for (genvar h = 0; h < HALVES; h++) begin : g_flag
        // Update the flag of half h from a matching command
        always_ff @(posedge clk) begin
            if (!rst_n)
                wp[h] <= 1'b0;
            else if (own_ram && (cmd.bank[BANK_W-2:SOCK_W] == h[BANK_W-SOCK_W-2:0]))
                wp[h] <= cmd.set;
        end
    end
endmodule

// File: rtl/pgmem_cs_decode.sv
// Chip select and upper address generation.
// Purely combinational; assumes in_win and slot_en describe the current cycle.
// Before the socket is known any enabled window access is served.
module pgmem_cs_decode
    import pgmem_pkg::*;
(
    input  logic              in_win,
    input  logic              slot_en,
    input  logic              cpu_wr,
    input  logic [BANK_W-1:0] bank_q,
    input  logic [SOCK_W-1:0] sock,
    input  logic              sock_vld,
    input  logic [HALVES-1:0] wp,
    output logic              ram_cs,
    output logic              rom_cs,
    output logic              mem_a14
);
    logic  ours;
    logic  hi;
    half_e half;

    assign half    = half_e'(bank_q[BANK_W-1:SOCK_W]);
    assign hi      = bank_q[SOCK_W];
    assign mem_a14 = hi;

    // Socket is addressed in the paged window
    assign ours = in_win & slot_en & (!sock_vld || (bank_q[SOCK_W-1:0] == sock));

    // Select the chip for the current half, gating protected RAM writes
    always_comb begin
        ram_cs = 1'b0;
        rom_cs = 1'b0;
        unique case (half)
            HALF_RAM_LO, HALF_RAM_HI: ram_cs = ours & ~(cpu_wr & wp[hi]);
            HALF_ROM_LO, HALF_ROM_HI: rom_cs = ours;
        endcase
    end
endmodule

// File: rtl/pgmem_ctrl.sv
// Paged memory bank controller, top level.
// Snoops bank-select register writes, learns its socket, keeps per-half
// write protect, and drives RAM/ROM selects and the upper address line.
// Assumes the host decoder supplies reg_sel and slot_en in the access cycle.
module pgmem_ctrl
    import pgmem_pkg::*;
#(
    parameter int              ADDR_W = 16,
    parameter int              DATA_W = 8,
    parameter logic [ADDR_W-1:0] WIN_LO = 16'h8000,
    parameter logic [ADDR_W-1:0] WIN_HI = 16'hBFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_wr,
    input  logic              reg_sel,
    input  logic              slot_en,
    output logic              ram_cs,
    output logic              rom_cs,
    output logic              mem_a14,
    output logic              ram_we
);
    logic [BANK_W-1:0] bank_q;
    prot_cmd_t         cmd;
    logic [SOCK_W-1:0] sock;
    logic              sock_vld;
    logic [HALVES-1:0] wp;
    logic              in_win;
    logic              rd_hit;

    // Window decode and qualifying read for socket learning
    assign in_win = (cpu_addr >= WIN_LO) && (cpu_addr <= WIN_HI);
    assign rd_hit = in_win & slot_en & ~cpu_wr;

    // Write enable passes straight through for timing
    assign ram_we = cpu_wr;

    pgmem_bank_reg #(.DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_sel  (reg_sel),
        .cpu_wr   (cpu_wr),
        .cpu_data (cpu_data),
        .bank_q   (bank_q),
        .cmd      (cmd)
    );

    pgmem_socket_id u_sock (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_hit   (rd_hit),
        .bank_q   (bank_q),
        .sock     (sock),
        .sock_vld (sock_vld)
    );

    pgmem_wp_flags u_wp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .sock     (sock),
        .sock_vld (sock_vld),
        .wp       (wp)
    );

    pgmem_cs_decode u_cs (
        .in_win   (in_win),
        .slot_en  (slot_en),
        .cpu_wr   (cpu_wr),
        .bank_q   (bank_q),
        .sock     (sock),
        .sock_vld (sock_vld),
        .wp       (wp),
        .ram_cs   (ram_cs),
        .rom_cs   (rom_cs),
        .mem_a14  (mem_a14)
    );
endmodule

// File: rtl/pgmem_ctrl_chk.sv
// Property checker for pgmem_ctrl, attached with bind below.
module pgmem_ctrl_chk
    import pgmem_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_data,
    input logic              cpu_wr,
    input logic              reg_sel,
    input logic              slot_en,
    input logic              ram_cs,
    input logic              rom_cs,
    input logic [BANK_W-1:0] bank_q,
    input logic [SOCK_W-1:0] sock,
    input logic              sock_vld,
    input logic [HALVES-1:0] wp
);
    AST_CS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cs || rom_cs) |-> (slot_en && cpu_addr[15:14] == 2'b10)); // R4

    AST_ONE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_cs && rom_cs)); // R3

    AST_BANK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && cpu_wr) |=> (bank_q == $past(cpu_data[BANK_W-1:0]))); // R2

    AST_SOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sock_vld |=> (sock_vld && $stable(sock))); // R5

    AST_NO_CS_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (sock_vld && bank_q[SOCK_W-1:0] != sock) |-> !(ram_cs || rom_cs)); // R6

    AST_WP_IDLE_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!sock_vld && !$past(sock_vld)) |-> (wp == '0)); // R9

    AST_WP_HIGH_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && cpu_wr && cpu_data[7:6] != 2'b00) |=> $stable(wp)); // R11
endmodule

bind pgmem_ctrl pgmem_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .cpu_wr   (cpu_wr),
    .reg_sel  (reg_sel),
    .slot_en  (slot_en),
    .ram_cs   (ram_cs),
    .rom_cs   (rom_cs),
    .bank_q   (bank_q),
    .sock     (sock),
    .sock_vld (sock_vld),
    .wp       (wp)
);

// File: tb/pgmem_ctrl_tb.sv
// Self-checking bench: vector table for a board in socket 2, then directed
// reset and ordering cases.
module pgmem_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic        slot_en = 1'b0;
    logic        ram_cs, rom_cs, mem_a14, ram_we;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pgmem_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .reg_sel(reg_sel), .slot_en(slot_en),
        .ram_cs(ram_cs), .rom_cs(rom_cs), .mem_a14(mem_a14), .ram_we(ram_we)
    );

    // kind: 0 read, 1 memory write, 2 register write, 3 reg_sel without write
    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] addr;
        logic [7:0]  data;
        logic        en;
        logic        chk;
        logic        ram;
        logic        rom;
        logic        a14;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 16'hFE30, 8'h0A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
        '{2'd0, 16'h8000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 learn socket 2
        '{2'd2, 16'hFE30, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},
        '{2'd1, 16'h8100, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 blocked write
        '{2'd0, 16'h8100, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 read passes
        '{2'd2, 16'hFE30, 8'h06, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
        '{2'd1, 16'h9000, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 RAM high
        '{2'd2, 16'hFE30, 8'h26, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},
        '{2'd1, 16'h9000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 set high half
        '{2'd2, 16'hFE30, 8'h32, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},
        '{2'd1, 16'h8000, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 clear low half
        '{2'd2, 16'hFE30, 8'h2A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},
        '{2'd0, 16'h8000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 ROM low
        '{2'd2, 16'hFE30, 8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
        '{2'd1, 16'h8000, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 ROM cmd no effect
        '{2'd2, 16'hFE30, 8'h21, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},
        '{2'd0, 16'h8000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 foreign bank
        '{2'd2, 16'hFE30, 8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
        '{2'd1, 16'h8000, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 foreign cmd no effect
        '{2'd2, 16'hFE30, 8'h62, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11},
        '{2'd1, 16'h8000, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd11}, // R11 0x62 not a set
        '{2'd2, 16'hFE30, 8'hB6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11},
        '{2'd1, 16'h9000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd11}, // R11 0xB6 not a clear
        '{2'd0, 16'hC000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 above window
        '{2'd0, 16'h7FFF, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 below window
        '{2'd0, 16'h9000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 socket disabled
        '{2'd3, 16'hFE30, 8'h0A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
        '{2'd0, 16'h9000, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2},  // R2 no capture without wr
        '{2'd2, 16'hFE30, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},
        '{2'd0, 16'h8000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 socket kept at 2
        '{2'd2, 16'hFE30, 8'h0E, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
        '{2'd0, 16'h8000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd3}   // R3 ROM high
    };

    task automatic check(input int req, input logic e_ram, input logic e_rom,
                         input logic e_a14, input logic e_we);
        checks++;
        if (ram_cs !== e_ram || rom_cs !== e_rom || mem_a14 !== e_a14 || ram_we !== e_we) begin
            errors++;
            $display("FAIL R%0d: ram_cs=%b rom_cs=%b a14=%b we=%b expected %b %b %b %b",
                     req, ram_cs, rom_cs, mem_a14, ram_we, e_ram, e_rom, e_a14, e_we);
        end
    endtask

    // Drive one bus cycle at the falling edge, then wait for the rising edge
    task automatic drive(input logic [1:0] kind, input logic [15:0] a,
                         input logic [7:0] d, input logic en);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        slot_en  = en;
        cpu_wr   = (kind == 2'd1) || (kind == 2'd2);
        reg_sel  = (kind == 2'd2) || (kind == 2'd3);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cpu_wr = 1'b0; reg_sel = 1'b0; slot_en = 1'b0; cpu_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();

        // Table walk: board in socket 2
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].kind, VEC[i].addr, VEC[i].data, VEC[i].en);
            if (VEC[i].chk)
                check(int'(VEC[i].req), VEC[i].ram, VEC[i].rom, VEC[i].a14, VEC[i].kind == 2'd1);
        end

        // R1 reset state: idle outputs, then first enabled read hits RAM low
        do_reset();
        drive(2'd0, 16'h0000, 8'h00, 1'b0);
        check(1, 1'b0, 1'b0, 1'b0, 1'b0); // R1 idle after reset
        // R9 set command for bank 0 while socket unknown must be ignored
        drive(2'd2, 16'hFE30, 8'h20, 1'b0);
        drive(2'd0, 16'h8000, 8'h00, 1'b1);
        check(5, 1'b1, 1'b0, 1'b0, 1'b0); // R5 first read served while learning socket 0
        drive(2'd1, 16'h8000, 8'h00, 1'b1);
        check(9, 1'b1, 1'b0, 1'b0, 1'b1); // R9 early command had no effect
        // R7 command right after learning takes effect on the next cycle
        drive(2'd2, 16'hFE30, 8'h20, 1'b0);
        drive(2'd1, 16'h8000, 8'h00, 1'b1);
        check(7, 1'b0, 1'b0, 1'b0, 1'b1); // R7 blocked immediately
        drive(2'd2, 16'hFE30, 8'h30, 1'b0);
        drive(2'd1, 16'h8000, 8'h00, 1'b1);
        check(7, 1'b1, 1'b0, 1'b0, 1'b1); // R7 released immediately

        // R1 fresh reset: bank 0 RAM low served on first enabled read
        do_reset();
        drive(2'd0, 16'hA000, 8'h00, 1'b1);
        check(1, 1'b1, 1'b0, 1'b0, 1'b0); // R1 reset bank 0
        // R10 protected write with flags reset clear still passes
        drive(2'd1, 16'hA000, 8'h00, 1'b1);
        check(10, 1'b1, 1'b0, 1'b0, 1'b1); // R10 unprotected write

        @(negedge clk);
        cpu_wr = 1'b0; reg_sel = 1'b0; slot_en = 1'b0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule